// File: doc/BRIEF.md
# Four-Channel Codec Control Command Port

This block is the byte-level control port of a four-channel voice codec. A host selects the port with an active-low chip select and sends a command byte. It then streams data bytes in, or pulls data bytes out, one per strobe. The command byte carries three things: the direction, a target class, and an address. The target class is a per-channel local register, a shared global register, a per-channel coefficient RAM block, or a per-channel FSK RAM block. A channel mask held in one of the global registers chooses which channels a local or RAM command reaches. A single write can therefore program several channels at once.

Local and global commands sequence a run of adjacent registers by themselves. The run starts at the addressed register and moves downward, and its length comes from the two low address bits. A RAM command moves a whole block of eight 14-bit words as sixteen bytes. On a legal read, the port returns an identification byte before any data. Raising chip select abandons the access in progress and everything after it. Accesses that have already finished keep their results.

Top module: `codec_ctl_port`

## Requirements
- R1: After reset, out_byte is 0xFF and every local, global, coefficient and FSK storage word reads as zero, including the channel mask.
- R2: Command byte fields: bit 7 is the direction (1 write, 0 read) and bits 6:5 the class (00 local, 01 global, 11 RAM). Bits 4:0 are the register address for local and global commands.
- R3: A local or global command with address A accesses registers A, A-1, ... down to the register whose two low bits are 00, which makes A[1:0]+1 accesses. Data bytes beyond the run are ignored.
- R4: On a legal read, the first output byte is 0x81. The run's data bytes follow in run order, and any request after the run ends returns 0xFF.
- R5: The channel mask is bits 3:0 of global register 6, with bit 0 for channel 1 up to bit 3 for channel 4. Local and RAM writes land in every enabled channel and leave disabled channels unchanged.
- R6: Global registers are shared and are read and written whatever the channel mask holds, including an empty mask.
- R7: The port ignores a command of class 10. It also ignores a local or RAM read unless exactly one channel is enabled. An ignored command changes nothing, and every output byte it produces is 0xFF.
- R8: When chip select rises in the middle of a run, the current access and all later ones are dropped, and completed ones keep their values. Storage never changes while chip select is high. The first byte after chip select falls is a command.
- R9: A RAM command with bit 4 = 0 uses bits 3:0 as a coefficient block number, valid from 0 to 4. A block holds 8 words of 14 bits, moved word 0 first, high byte before low byte. High-byte bits 7:6 are dropped on write and read as 0. A word is stored when its low byte arrives. Blocks 5 to 15 are ignored.
- R10: A RAM command with bit 4 = 1 addresses FSK RAM. Bit 3 must be 0, and bits 2:0 select a block below FSK_BLOCKS (default 2) with the same word and byte layout. Any other value is ignored.
- R11: out_byte changes only at a clock edge where out_req is high. During a write, or before a command, a request returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high aborts and idles the port |
| in_valid | input | 1 | in_byte is valid this cycle |
| in_byte | input | 8 | Command or write data byte |
| out_req | input | 1 | Request for the next output byte |
| out_byte | output | 8 | Registered output byte |

## Verification
Each write byte is captured at the clock edge where in_valid is seen high, and storage is visible to any later transaction. Each requested output byte appears in out_byte right after the edge that samples out_req and holds until the next request. The bench raises a strobe half a period before an edge and compares out_byte against its model two nanoseconds after every edge. A model value therefore always lines up with the single register between the strobe and the port.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    typedef enum logic [2:0] {
        K_LOCAL,
        K_GLOBAL,
        K_COEF,
        K_FSK,
        K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_WR,
        PH_RD_ID,
        PH_RD,
        PH_NULL
    } phase_e;

    localparam logic [7:0] ID_BYTE   = 8'h81;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    typedef struct packed {
        phase_e      phase;
        kind_e       kind;
        logic [4:0]  ptr;    // register address, or word index in [2:0]
        logic        lo;     // next RAM byte is the low byte
        logic [4:0]  left;   // accesses remaining in the run
        logic [3:0]  blk;
        logic [5:0]  hold;   // staged high bits of a RAM word
        logic [7:0]  obyte;
    } st_t;

    localparam st_t ST_RST = '{
        phase: PH_CMD, kind: K_BAD, ptr: 5'd0, lo: 1'b0,
        left: 5'd0, blk: 4'd0, hold: 6'd0, obyte: IDLE_BYTE
    };

endpackage

// File: rtl/codec_cmd_decode.sv
module codec_cmd_decode
    import codec_ctl_pkg::*;
#(
    parameter int COEF_BLOCKS = 5,
    parameter int FSK_BLOCKS  = 2
) (
    input  logic [7:0] cmd,
    output logic       is_wr,
    output kind_e      kind,
    output logic [4:0] run_len,
    output logic [4:0] start_ptr,
    output logic [3:0] blk
);
    localparam logic [4:0] CB_LIM = 5'(COEF_BLOCKS);
    localparam logic [3:0] FB_LIM = 4'(FSK_BLOCKS);

    always_comb begin
        is_wr     = cmd[7];
        kind      = K_BAD;
        run_len   = 5'd0;
        start_ptr = cmd[4:0];
        blk       = cmd[3:0];
        unique case (cmd[6:5])
            2'b00: begin
                kind    = K_LOCAL;
                run_len = {3'b000, cmd[1:0]} + 5'd1;
            end
            2'b01: begin
                kind    = K_GLOBAL;
                run_len = {3'b000, cmd[1:0]} + 5'd1;
            end
            2'b11: begin
                start_ptr = 5'd0;
                run_len   = 5'd16;
                if (!cmd[4]) begin
                    if ({1'b0, cmd[3:0]} < CB_LIM) kind = K_COEF;
                end else if (!cmd[3] && ({1'b0, cmd[2:0]} < FB_LIM)) begin
                    kind = K_FSK;
                    blk  = {1'b0, cmd[2:0]};
                end
            end
            default: kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/codec_word_bank.sv
module codec_word_bank #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we && (int'(waddr) < DEPTH)) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH) rdata = mem_q[raddr];
    end
endmodule

// File: rtl/codec_glb_regs.sv
module codec_glb_regs #(
    parameter int NREG      = 32,
    parameter int NCH       = 4,
    parameter int CHEN_ADDR = 6,
    localparam int AW       = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    output logic [NCH-1:0] chan_en
);
    logic [7:0] reg_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
        end else if (we) begin
            reg_q[addr] <= wdata;
        end
    end

    assign rdata   = reg_q[addr];
    assign chan_en = reg_q[CHEN_ADDR][NCH-1:0];
endmodule

// File: rtl/codec_ctl_port.sv
module codec_ctl_port
    import codec_ctl_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int COEF_BLOCKS = 5,
    parameter int FSK_BLOCKS  = 2,
    parameter int CHEN_ADDR   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       out_req,
    output logic [7:0] out_byte
);
    localparam int NREG   = 32;
    localparam int WPB    = 8;
    localparam int CW     = 14;
    localparam int CDEPTH = COEF_BLOCKS * WPB;
    localparam int FDEPTH = FSK_BLOCKS * WPB;
    localparam int CAW    = $clog2(CDEPTH);
    localparam int FAW    = $clog2(FDEPTH);

    st_t st_q, st_d;

    // decoder
    logic       dec_wr;
    kind_e      dec_kind;
    logic [4:0] dec_len, dec_ptr;
    logic [3:0] dec_blk;

    codec_cmd_decode #(
        .COEF_BLOCKS(COEF_BLOCKS),
        .FSK_BLOCKS (FSK_BLOCKS)
    ) dec_i (
        .cmd      (in_byte),
        .is_wr    (dec_wr),
        .kind     (dec_kind),
        .run_len  (dec_len),
        .start_ptr(dec_ptr),
        .blk      (dec_blk)
    );

    // storage
    logic [NCH-1:0] chan_en, loc_we, coef_we, fsk_we;
    logic           glb_we;
    logic [7:0]     glb_rd;
    logic [7:0]     loc_rd  [NCH];
    logic [CW-1:0]  coef_rd [NCH];
    logic [CW-1:0]  fsk_rd  [NCH];
    logic [CW-1:0]  ram_wdata;
    logic [CAW-1:0] coef_addr;
    logic [FAW-1:0] fsk_addr;

    assign ram_wdata = {st_q.hold, in_byte};
    assign coef_addr = CAW'({st_q.blk, st_q.ptr[2:0]});
    assign fsk_addr  = FAW'({st_q.blk, st_q.ptr[2:0]});

    codec_glb_regs #(
        .NREG     (NREG),
        .NCH      (NCH),
        .CHEN_ADDR(CHEN_ADDR)
    ) glb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (glb_we),
        .addr   (st_q.ptr),
        .wdata  (in_byte),
        .rdata  (glb_rd),
        .chan_en(chan_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        codec_word_bank #(.DEPTH(NREG), .WIDTH(8)) loc_i (
            .clk(clk), .rst_n(rst_n), .we(loc_we[g]),
            .waddr(st_q.ptr), .wdata(in_byte),
            .raddr(st_q.ptr), .rdata(loc_rd[g])
        );
        codec_word_bank #(.DEPTH(CDEPTH), .WIDTH(CW)) coef_i (
            .clk(clk), .rst_n(rst_n), .we(coef_we[g]),
            .waddr(coef_addr), .wdata(ram_wdata),
            .raddr(coef_addr), .rdata(coef_rd[g])
        );
        codec_word_bank #(.DEPTH(FDEPTH), .WIDTH(CW)) fsk_i (
            .clk(clk), .rst_n(rst_n), .we(fsk_we[g]),
            .waddr(fsk_addr), .wdata(ram_wdata),
            .raddr(fsk_addr), .rdata(fsk_rd[g])
        );
    end

    // read data selection for the single enabled channel
    logic [7:0]    loc_sel, rd_byte;
    logic [CW-1:0] coef_sel, fsk_sel, word_sel;
    logic          one_ch;

    always_comb begin
        loc_sel  = '0;
        coef_sel = '0;
        fsk_sel  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (chan_en[i]) begin
                loc_sel  = loc_sel  | loc_rd[i];
                coef_sel = coef_sel | coef_rd[i];
                fsk_sel  = fsk_sel  | fsk_rd[i];
            end
        end
        one_ch   = ($countones(chan_en) == 1);
        word_sel = (st_q.kind == K_FSK) ? fsk_sel : coef_sel;
        unique case (st_q.kind)
            K_LOCAL:  rd_byte = loc_sel;
            K_GLOBAL: rd_byte = glb_rd;
            K_COEF,
            K_FSK:    rd_byte = st_q.lo ? word_sel[7:0] : 8'(word_sel[CW-1:8]);
            default:  rd_byte = IDLE_BYTE;
        endcase
    end

    // next-state logic
    always_comb begin
        st_d    = st_q;
        loc_we  = '0;
        coef_we = '0;
        fsk_we  = '0;
        glb_we  = 1'b0;

        if (cs_n) begin
            st_d       = ST_RST;
            st_d.obyte = st_q.obyte;
        end else begin
            if (out_req) st_d.obyte = IDLE_BYTE;
            unique case (st_q.phase)
                PH_CMD: begin
                    if (in_valid) begin
                        st_d.kind = dec_kind;
                        st_d.ptr  = dec_ptr;
                        st_d.left = dec_len;
                        st_d.blk  = dec_blk;
                        st_d.lo   = 1'b0;
                        if (dec_kind == K_BAD)
                            st_d.phase = PH_NULL;
                        else if (dec_wr)
                            st_d.phase = PH_WR;
                        else if (dec_kind != K_GLOBAL && !one_ch)
                            st_d.phase = PH_NULL;
                        else
                            st_d.phase = PH_RD_ID;
                    end
                end
                PH_WR: begin
                    if (in_valid && st_q.left != 5'd0) begin
                        unique case (st_q.kind)
                            K_LOCAL:  loc_we = chan_en;
                            K_GLOBAL: glb_we = 1'b1;
                            K_COEF:   if (st_q.lo) coef_we = chan_en;
                            K_FSK:    if (st_q.lo) fsk_we  = chan_en;
                            default:  ;
                        endcase
                        if (!st_q.lo) st_d.hold = in_byte[5:0];
                        st_d.left = st_q.left - 5'd1;
                        if (st_q.kind == K_LOCAL || st_q.kind == K_GLOBAL) begin
                            st_d.ptr = st_q.ptr - 5'd1;
                        end else if (st_q.lo) begin
                            st_d.lo  = 1'b0;
                            st_d.ptr = st_q.ptr + 5'd1;
                        end else begin
                            st_d.lo = 1'b1;
                        end
                    end
                end
                PH_RD_ID: begin
                    if (out_req) begin
                        st_d.obyte = ID_BYTE;
                        st_d.phase = PH_RD;
                    end
                end
                PH_RD: begin
                    if (out_req && st_q.left != 5'd0) begin
                        st_d.obyte = rd_byte;
                        st_d.left  = st_q.left - 5'd1;
                        if (st_q.kind == K_LOCAL || st_q.kind == K_GLOBAL) begin
                            st_d.ptr = st_q.ptr - 5'd1;
                        end else if (st_q.lo) begin
                            st_d.lo  = 1'b0;
                            st_d.ptr = st_q.ptr + 5'd1;
                        end else begin
                            st_d.lo = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign out_byte = st_q.obyte;

endmodule

// File: rtl/codec_ctl_port_chk.sv
module codec_ctl_port_chk
    import codec_ctl_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic           out_req,
    input logic [7:0]     out_byte,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] loc_we,
    input logic           glb_we,
    input logic [NCH-1:0] coef_we,
    input logic [NCH-1:0] fsk_we,
    input phase_e         phase
);
    a_r11_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !out_req |=> $stable(out_byte));

    a_r8_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (loc_we == '0 && !glb_we && coef_we == '0 && fsk_we == '0));

    a_r5_writes_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((loc_we & ~chan_en) == '0) && ((coef_we & ~chan_en) == '0)
        && ((fsk_we & ~chan_en) == '0));

    a_r4_id_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && out_req && phase == PH_RD_ID) |=> (out_byte == ID_BYTE));

    a_r7_read_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RD_ID || phase == PH_RD || phase == PH_NULL)
        |-> (loc_we == '0 && !glb_we && coef_we == '0 && fsk_we == '0));

    a_r9_ram_one_channel_word: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|coef_we, |fsk_we, |loc_we, glb_we}));
endmodule

bind codec_ctl_port codec_ctl_port_chk #(.NCH(NCH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .out_req (out_req),
    .out_byte(out_byte),
    .chan_en (chan_en),
    .loc_we  (loc_we),
    .glb_we  (glb_we),
    .coef_we (coef_we),
    .fsk_we  (fsk_we),
    .phase   (st_q.phase)
);

// File: tb/codec_ctl_port_tb.sv
`timescale 1ns/1ps
module codec_ctl_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_req = 1'b0;
    logic [7:0] out_byte;

    always #2.5 clk = ~clk;

    codec_ctl_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .in_valid(in_valid),
        .in_byte(in_byte), .out_req(out_req), .out_byte(out_byte)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;
    string tag = "R1";
    logic [7:0] exp_out = 8'hFF;

    // behavioural model
    int loc  [4][32];
    int glb  [32];
    int coef [4][40];
    int fsk  [4][16];
    int m_q [$];
    int m_kind = -1;  // -1 none, 0 local, 1 global, 2 coef, 3 fsk, 4 ignored
    bit m_wr, m_id, m_readable;
    int m_blk, m_hold;

    function automatic logic [3:0] chan();
        return glb[6][3:0];
    endfunction

    function automatic int sel_ch();
        for (int c = 0; c < 4; c++) if (chan()[c]) return c;
        return 0;
    endfunction

    task automatic model_cmd(input logic [7:0] b);
        int a;
        m_q.delete();
        m_wr = b[7];
        a = int'(b[4:0]);
        m_kind = 4;
        case (b[6:5])
            2'b00, 2'b01: begin
                m_kind = (b[6:5] == 2'b00) ? 0 : 1;
                for (int i = a; i >= (a & ~3); i--) m_q.push_back(i);
            end
            2'b11: begin
                if (!b[4] && b[3:0] < 5) begin m_kind = 2; m_blk = int'(b[3:0]); end
                else if (b[4] && !b[3] && b[2:0] < 2) begin m_kind = 3; m_blk = int'(b[2:0]); end
                if (m_kind != 4) for (int i = 0; i < 16; i++) m_q.push_back(i);
            end
            default: m_kind = 4;
        endcase
        m_readable = !m_wr && m_kind != 4 && (m_kind == 1 || $countones(chan()) == 1);
        m_id = m_readable;
    endtask

    task automatic model_write(input logic [7:0] b);
        int idx, w;
        logic [3:0] ce;
        if (!m_wr || m_kind == 4 || m_q.size() == 0) return;
        idx = m_q.pop_front();
        ce = chan();
        if (m_kind == 1) glb[idx] = int'(b);
        else if (m_kind == 0) begin
            for (int c = 0; c < 4; c++) if (ce[c]) loc[c][idx] = int'(b);
        end else if (idx % 2 == 0) m_hold = int'(b[5:0]);
        else begin
            w = m_blk * 8 + idx / 2;
            for (int c = 0; c < 4; c++) if (ce[c]) begin
                if (m_kind == 2) coef[c][w] = m_hold * 256 + int'(b);
                else fsk[c][w] = m_hold * 256 + int'(b);
            end
        end
    endtask

    function automatic logic [7:0] model_read();
        int idx, w, ch;
        if (m_kind == -1 || m_wr || !m_readable) return 8'hFF;
        if (m_id) begin m_id = 1'b0; return 8'h81; end
        if (m_q.size() == 0) return 8'hFF;
        idx = m_q.pop_front();
        ch = sel_ch();
        if (m_kind == 0) return 8'(loc[ch][idx]);
        if (m_kind == 1) return 8'(glb[idx]);
        w = (m_kind == 2) ? coef[ch][m_blk * 8 + idx / 2] : fsk[ch][m_blk * 8 + idx / 2];
        return (idx % 2 == 0) ? 8'(w / 256) : 8'(w % 256);
    endfunction

    // compare on every clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (mon_en && !done) begin
            checks++;
            if (out_byte !== exp_out) begin
                errors++;
                $display("FAIL %s: out_byte=%h expected=%h at %0t", tag, out_byte, exp_out, $time);
            end
        end
    end

    task automatic sel();
        @(negedge clk) cs_n = 1'b0;
    endtask

    task automatic desel();
        @(negedge clk) cs_n = 1'b1;
        m_kind = -1;
        m_q.delete();
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        if (m_kind == -1) model_cmd(b);
        else model_write(b);
        @(negedge clk) in_valid = 1'b0;
    endtask

    task automatic req();
        @(negedge clk);
        out_req = 1'b1;
        exp_out = model_read();
        @(negedge clk) out_req = 1'b0;
    endtask

    task automatic set_chan(input logic [7:0] m);
        sel(); send(8'hA6); send(m); desel();
    endtask

    task automatic rd(input logic [7:0] cmd, input int n);
        sel(); send(cmd);
        for (int i = 0; i < n; i++) req();
        desel();
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 32; i++) loc[c][i] = 0;
            for (int i = 0; i < 40; i++) coef[c][i] = 0;
            for (int i = 0; i < 16; i++) fsk[c][i] = 0;
        end
        for (int i = 0; i < 32; i++) glb[i] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R1 reset state, R4 ID then run, R6 global read with empty mask
        tag = "R1"; repeat (2) @(negedge clk);
        tag = "R6"; rd(8'h26, 5);

        // R3 global write run of 3 with an extra ignored byte
        tag = "R3";
        sel(); send(8'hA6); send(8'h0F); send(8'h55); send(8'hAA); send(8'h77); desel();
        tag = "R4"; rd(8'h26, 5);
        tag = "R2"; rd(8'h27, 6);

        // R5 broadcast local write, then per-channel reads
        tag = "R5";
        sel(); send(8'h8B); send(8'h11); send(8'h22); send(8'h33); send(8'h44); desel();
        set_chan(8'h04); rd(8'h0B, 5);
        set_chan(8'h02);
        sel(); send(8'h89); send(8'h99); send(8'h88); desel();
        rd(8'h0B, 5);
        set_chan(8'h04); rd(8'h0B, 5);

        // R11 request during a write returns 0xFF
        tag = "R11";
        sel(); send(8'h80); req(); send(8'h5A); req(); desel();
        rd(8'h00, 2);

        // R7 ignored reads and illegal class
        tag = "R7";
        set_chan(8'h06); rd(8'h0B, 4);
        set_chan(8'h00); rd(8'h0B, 3); rd(8'h63, 3);
        set_chan(8'h02);
        sel(); send(8'hCB); send(8'hDE); send(8'hAD); req(); desel();
        rd(8'h0B, 5); rd(8'h4B, 3);

        // R8 abort mid-run
        tag = "R8";
        set_chan(8'h01);
        sel(); send(8'h8F); send(8'h01); send(8'h02); desel();
        rd(8'h0F, 6);
        sel(); send(8'h0F); req(); req(); desel();
        rd(8'h0F, 3);

        // R9 coefficient block write broadcast to two channels
        tag = "R9";
        set_chan(8'h03);
        sel(); send(8'hE3);
        for (int k = 0; k < 8; k++) begin send(8'(8'hC0 | k)); send(8'(8'h10 + k)); end
        desel();
        set_chan(8'h01); rd(8'h63, 18);
        set_chan(8'h02); rd(8'h63, 18);
        set_chan(8'h04); rd(8'h63, 4);
        sel(); send(8'hE5); send(8'h3F); send(8'hFF); desel();
        rd(8'h65, 3);
        sel(); send(8'hE0); send(8'h2A); desel();
        rd(8'h60, 4);

        // R10 FSK block and reserved encodings
        tag = "R10";
        set_chan(8'h08);
        sel(); send(8'hF1);
        for (int k = 0; k < 8; k++) begin send(8'(k * 3)); send(8'(8'hA0 + k)); end
        desel();
        rd(8'h71, 18);
        sel(); send(8'hF9); send(8'h01); send(8'h02); desel();
        rd(8'h79, 3); rd(8'h72, 3); rd(8'h70, 4);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule